// File: doc/BRIEF.md
# Byte-wide nonvolatile data store controller

This block lets a processor read and write single bytes of a small on-chip nonvolatile store. The store is modelled as a register array of 128 bytes. The processor does not address the store directly. It reaches it through four byte registers selected by a two-bit register select: a data register, an address register, a control register, and an unlock register that holds nothing. A read takes one clock. A write is timed. It first erases the addressed byte to 0xFF and then programs it with the value in the data register. A completion flag, which also drives the interrupt line, marks the end of the write.

The start bits for read and write can only be set by software. Hardware clears them. A write starts only if write enable was already set and the two register writes just before the start request were 0x55 and then 0xAA to the unlock register. A warm reset (master clear or watchdog) that arrives during a write stops the write and sets a sticky error flag. The address and data registers keep their values, so software can retry the write.

The sequencer moves through four named states: IDLE, READ, ERASE and PROGRAM. Its transitions are:
- IDLE to ERASE on an accepted write start.
- IDLE to READ on a read request.
- READ to IDLE after one cycle.
- ERASE to PROGRAM when the erase half of the timer runs out.
- PROGRAM to IDLE when the program half of the timer runs out.
- ERASE or PROGRAM to IDLE on a warm reset. This transition is the abort.

Top module: `nvb_ctrl`

## Requirements
- R1: After power-on reset (rst_n low), the data, address and control registers read 0x00, irq is low, and every store byte is 0xFF. Register select codes: 0 is data, 1 is address, 2 is control, 3 is unlock. Control bits: bit0 RDGO (read start), bit1 WRGO (write start), bit2 WEN (write enable), bit3 WERR (write error), bit4 WDONE (write complete).
- R2: The address register is 8 bits. Bits 6:0 select one of 128 bytes. When bit 7 is 1, a read returns 0x00 and a write, though fully timed and flagged, leaves the store unchanged.
- R3: Writing control with bit0=1 while idle sets RDGO. At the next clock edge the data register takes the addressed byte and RDGO reads 0 again.
- R4: Software cannot clear RDGO or WRGO. Writing 0 to bit1 during a write leaves WRGO set.
- R5: A write starts only if WEN was already 1, the written byte has bit1=1, and the two register writes immediately before it were 0x55 and then 0xAA to the unlock register. Otherwise WRGO stays 0 and the store is unchanged.
- R6: WRGO reads 1 for exactly WRITE_CYC cycles after the start request. After the first WRITE_CYC/2 cycles the byte holds 0xFF. At the end it holds the data register value.
- R7: While WRGO is 1, writes to the data and address registers are ignored.
- R8: When a write completes, WRGO clears and WDONE and irq go high. Writing 0 to bit4 clears WDONE. Writing 1 to bit4 leaves it unchanged.
- R9: A warm reset during a write sets WERR, clears WRGO and WEN, and keeps the address and data registers. A warm reset while idle leaves WERR unchanged. Writing 0 to bit3 clears WERR.
- R10: The unlock register always reads 0x00. Control bits 7:5 always read 0.
- R11: A read request made while a write is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| warm_rst | input | 1 | Synchronous warm reset (master clear or watchdog) |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Write-complete interrupt (WDONE) |

## Verification
The checker verifies on every cycle that:
- RDGO lasts one cycle and never coexists with WRGO.
- A write start is always preceded by WEN.
- Address and data stay frozen through a write.
- A completed write raises WDONE, and an aborted one raises WERR.
- The unlock register and the upper control bits read zero.

Only the bench scenarios can show the following: that every store byte takes the programmed value, that a write lasts exactly WRITE_CYC cycles, that the erase leaves 0xFF partway through, and that wrong or broken unlock sequences, writes without enable, and out-of-range addresses leave the store untouched.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
    localparam logic [1:0] SEL_DATA   = 2'd0;
    localparam logic [1:0] SEL_ADDR   = 2'd1;
    localparam logic [1:0] SEL_CTRL   = 2'd2;
    localparam logic [1:0] SEL_UNLOCK = 2'd3;

    localparam int BIT_RDGO  = 0;
    localparam int BIT_WRGO  = 1;
    localparam int BIT_WEN   = 2;
    localparam int BIT_WERR  = 3;
    localparam int BIT_WDONE = 4;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;
    localparam logic [7:0] ERASED     = 8'hFF;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_READ,
        SQ_ERASE,
        SQ_PROGRAM
    } seq_state_e;

    typedef enum logic [1:0] {
        UL_NONE,
        UL_HALF,
        UL_ARMED
    } unlock_e;
endpackage

// File: rtl/nvb_unlock.sv
module nvb_unlock
    import nvb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       warm_rst,
    input  logic       bus_wr,
    input  logic [1:0] bus_sel,
    input  logic [7:0] bus_wdata,
    output logic       armed
);
    unlock_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (warm_rst) begin
            state_d = UL_NONE;
        end else if (bus_wr) begin
            unique case (state_q)
                UL_NONE, UL_ARMED: begin
                    if (bus_sel == SEL_UNLOCK && bus_wdata == KEY_FIRST)
                        state_d = UL_HALF;
                    else
                        state_d = UL_NONE;
                end
                UL_HALF: begin
                    if (bus_sel == SEL_UNLOCK && bus_wdata == KEY_SECOND)
                        state_d = UL_ARMED;
                    else if (bus_sel == SEL_UNLOCK && bus_wdata == KEY_FIRST)
                        state_d = UL_HALF;
                    else
                        state_d = UL_NONE;
                end
                default: state_d = UL_NONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UL_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        armed = (state_q == UL_ARMED);
    end
endmodule

// File: rtl/nvb_seq.sv
module nvb_seq
    import nvb_pkg::*;
#(
    parameter int WRITE_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic warm_rst,
    input  logic rd_req,
    input  logic wr_req,
    output logic rd_active,
    output logic wr_active,
    output logic erase_we,
    output logic prog_we,
    output logic abort
);
    localparam int ERASE_CYC = (WRITE_CYC / 2 < 1) ? 1 : WRITE_CYC / 2;
    localparam int PROG_CYC  = (WRITE_CYC - ERASE_CYC < 1) ? 1 : WRITE_CYC - ERASE_CYC;
    localparam int CW        = $clog2(WRITE_CYC + 1);
    localparam logic [CW-1:0] ERASE_LAST = CW'(ERASE_CYC - 1);
    localparam logic [CW-1:0] PROG_LAST  = CW'(PROG_CYC - 1);

    seq_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (wr_req)      state_d = SQ_ERASE;
                else if (rd_req) state_d = SQ_READ;
            end
            SQ_READ:    state_d = SQ_IDLE;
            SQ_ERASE:   if (cnt_q == ERASE_LAST) state_d = SQ_PROGRAM;
            SQ_PROGRAM: if (cnt_q == PROG_LAST)  state_d = SQ_IDLE;
            default:    state_d = SQ_IDLE;
        endcase
        if (warm_rst) state_d = SQ_IDLE;
        cnt_d = (state_d != state_q) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        rd_active = (state_q == SQ_READ);
        wr_active = (state_q == SQ_ERASE) || (state_q == SQ_PROGRAM);
        erase_we  = (state_q == SQ_ERASE)   && (cnt_q == ERASE_LAST) && !warm_rst;
        prog_we   = (state_q == SQ_PROGRAM) && (cnt_q == PROG_LAST)  && !warm_rst;
        abort     = wr_active && warm_rst;
    end
endmodule

// File: rtl/nvb_store.sv
module nvb_store #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
        end else if (we) begin
            cells[addr] <= wdata;
        end
    end

    always_comb begin
        rdata = cells[addr];
    end
endmodule

// File: rtl/nvb_ctrl.sv
module nvb_ctrl
    import nvb_pkg::*;
#(
    parameter int WRITE_CYC = 64,
    parameter int ADDR_BITS = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       warm_rst,
    input  logic [1:0] reg_sel,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq
);
    logic [7:0] data_q, addr_q;
    logic       wren_q, wrerr_q, done_q;
    logic       armed, rd_active, wr_active, erase_we, prog_we, abort;
    logic       in_range, bus_ok, ctl_wr, rd_req, wr_req, store_we;
    logic [7:0] store_rdata, store_wdata;

    generate
        if (ADDR_BITS < 8) begin : g_decode
            assign in_range = ~|addr_q[7:ADDR_BITS];
        end else begin : g_full
            assign in_range = 1'b1;
        end
    endgenerate

    always_comb begin
        bus_ok = reg_wr && !warm_rst;
        ctl_wr = bus_ok && (reg_sel == SEL_CTRL);
        rd_req = ctl_wr && reg_wdata[BIT_RDGO];
        wr_req = ctl_wr && reg_wdata[BIT_WRGO] && wren_q && armed;
    end

    nvb_unlock u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .warm_rst  (warm_rst),
        .bus_wr    (reg_wr),
        .bus_sel   (reg_sel),
        .bus_wdata (reg_wdata),
        .armed     (armed)
    );

    nvb_seq #(.WRITE_CYC(WRITE_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .warm_rst  (warm_rst),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .rd_active (rd_active),
        .wr_active (wr_active),
        .erase_we  (erase_we),
        .prog_we   (prog_we),
        .abort     (abort)
    );

    always_comb begin
        store_we    = (erase_we || prog_we) && in_range;
        store_wdata = erase_we ? ERASED : data_q;
    end

    nvb_store #(.AW(ADDR_BITS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store_we),
        .addr  (addr_q[ADDR_BITS-1:0]),
        .wdata (store_wdata),
        .rdata (store_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            addr_q <= '0;
        end else begin
            if (rd_active && !warm_rst)
                data_q <= in_range ? store_rdata : 8'h00;
            else if (bus_ok && reg_sel == SEL_DATA && !wr_active)
                data_q <= reg_wdata;
            if (bus_ok && reg_sel == SEL_ADDR && !wr_active)
                addr_q <= reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wren_q  <= 1'b0;
            wrerr_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            if (warm_rst)    wren_q <= 1'b0;
            else if (ctl_wr) wren_q <= reg_wdata[BIT_WEN];

            if (abort)       wrerr_q <= 1'b1;
            else if (ctl_wr) wrerr_q <= wrerr_q && reg_wdata[BIT_WERR];

            if (prog_we)     done_q <= 1'b1;
            else if (ctl_wr) done_q <= done_q && reg_wdata[BIT_WDONE];
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        unique case (reg_sel)
            SEL_DATA: reg_rdata = data_q;
            SEL_ADDR: reg_rdata = addr_q;
            SEL_CTRL: reg_rdata = {3'b000, done_q, wrerr_q, wren_q, wr_active, rd_active};
            SEL_UNLOCK: reg_rdata = 8'h00;
            default: reg_rdata = 8'h00;
        endcase
        irq = done_q;
    end
endmodule

// File: rtl/nvb_ctrl_chk.sv
module nvb_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       warm_rst,
    input logic [1:0] reg_sel,
    input logic [7:0] reg_rdata,
    input logic       rd_bit,
    input logic       wr_bit,
    input logic       wren,
    input logic       wrerr,
    input logic       done,
    input logic [7:0] addr_q,
    input logic [7:0] data_q
);
    a_r3_rd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bit |=> !rd_bit);

    a_r5_start_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_bit) |-> $past(wren));

    a_r7_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_bit) && wr_bit) |-> ($stable(addr_q) && $stable(data_q)));

    a_r8_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_bit) && !wr_bit && !$past(warm_rst)) |-> done);

    a_r9_abort_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_bit) && $past(warm_rst)) |-> (wrerr && !wr_bit && !wren));

    a_r10_unlock_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd3) |-> (reg_rdata == 8'h00));

    a_r10_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd2) |-> (reg_rdata[7:5] == 3'b000));

    a_r11_no_read_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bit |-> !rd_bit);
endmodule

bind nvb_ctrl nvb_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .warm_rst  (warm_rst),
    .reg_sel   (reg_sel),
    .reg_rdata (reg_rdata),
    .rd_bit    (rd_active),
    .wr_bit    (wr_active),
    .wren      (wren_q),
    .wrerr     (wrerr_q),
    .done      (done_q),
    .addr_q    (addr_q),
    .data_q    (data_q)
);

// File: tb/tb_nvb_ctrl.sv
module tb_nvb_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WCYC       = 16;
    localparam int ECYC       = WCYC / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       warm_rst = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    int total = 0;
    int fails = 0;
    int cyc   = 0;

    nvb_ctrl #(.WRITE_CYC(WCYC), .ADDR_BITS(7)) dut (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total = total + 1;
            fails = fails + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 8'hFF);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] sel, output logic [7:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic start_write(input logic [7:0] a, input logic [7:0] d);
        bus_write(2'd1, a);
        bus_write(2'd0, d);
        bus_write(2'd2, 8'h1C);
        bus_write(2'd3, 8'h55);
        bus_write(2'd3, 8'hAA);
        bus_write(2'd2, 8'h1E);
    endtask

    task automatic wait_write(output int n);
        logic [7:0] v;
        n = 0;
        for (int k = 0; k < 4 * WCYC; k++) begin
            peek(2'd2, v);
            if (!v[1]) break;
            n = n + 1;
            @(negedge clk);
        end
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] d);
        logic [7:0] v;
        bus_write(2'd1, a);
        bus_write(2'd2, 8'h19);
        peek(2'd2, v);
        check(v[0] == 1'b1, "R3 RDGO set", v[0], 1);
        @(negedge clk);
        peek(2'd2, v);
        check(v[0] == 1'b0, "R3 RDGO self-clear", v[0], 0);
        peek(2'd0, d);
    endtask

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        peek(2'd0, v); check(v == 8'h00, "R1 data reset", v, 0);
        peek(2'd1, v); check(v == 8'h00, "R1 addr reset", v, 0);
        peek(2'd2, v); check(v == 8'h00, "R1 ctrl reset", v, 0);
        check(irq == 1'b0, "R1 irq reset", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);

        do_read(8'h22, v); check(v == 8'hFF, "R1 store erased at reset", v, 8'hFF);

        // R6 R8: full sweep of every location
        for (int a = 0; a < 128; a++) begin
            start_write(8'(a), pat(a));
            wait_write(n);
            if (a < 4 || a == 127) check(n == WCYC, "R6 write duration", n, WCYC);
            peek(2'd2, v);
            check(v[4] && irq, "R8 WDONE after write", v, 8'h10);
            if (a == 0) begin
                bus_write(2'd2, 8'h10);
                peek(2'd2, v); check(v[4] == 1'b1, "R8 writing 1 keeps WDONE", v[4], 1);
                bus_write(2'd2, 8'h00);
                peek(2'd2, v); check(v[4] == 1'b0 && !irq, "R8 writing 0 clears WDONE", v[4], 0);
            end
        end
        for (int a = 0; a < 128; a++) begin
            do_read(8'(a), v);
            check(v == pat(a), "R6 stored byte", v, pat(a));
        end

        // R10 read-only zero fields
        bus_write(2'd3, 8'hFF);
        peek(2'd3, v); check(v == 8'h00, "R10 unlock reads zero", v, 0);
        bus_write(2'd2, 8'hE4);
        peek(2'd2, v); check(v[7:5] == 3'b000, "R10 ctrl upper bits", v, 8'h04);

        // R5: no prior WEN
        bus_write(2'd1, 8'h05); bus_write(2'd0, 8'h99);
        bus_write(2'd2, 8'h00);
        bus_write(2'd3, 8'h55); bus_write(2'd3, 8'hAA);
        bus_write(2'd2, 8'h06);
        peek(2'd2, v); check(v[1] == 1'b0, "R5 no start without WEN", v[1], 0);
        // R5: reversed keys
        bus_write(2'd2, 8'h04);
        bus_write(2'd3, 8'hAA); bus_write(2'd3, 8'h55);
        bus_write(2'd2, 8'h06);
        peek(2'd2, v); check(v[1] == 1'b0, "R5 reversed keys", v[1], 0);
        // R5: interrupted sequence
        bus_write(2'd2, 8'h04);
        bus_write(2'd3, 8'h55); bus_write(2'd0, 8'h99); bus_write(2'd3, 8'hAA);
        bus_write(2'd2, 8'h06);
        peek(2'd2, v); check(v[1] == 1'b0, "R5 broken sequence", v[1], 0);
        repeat (WCYC + 2) @(negedge clk);
        do_read(8'h05, v); check(v == pat(5), "R5 store untouched", v, pat(5));

        // R4 R7 R11 during a write
        start_write(8'h30, 8'h5A);
        bus_write(2'd2, 8'h05);
        peek(2'd2, v);
        check(v[1] == 1'b1, "R4 WRGO not cleared by software", v[1], 1);
        check(v[0] == 1'b0, "R11 read ignored during write", v[0], 0);
        bus_write(2'd0, 8'h11); bus_write(2'd1, 8'h31);
        peek(2'd0, v); check(v == 8'h5A, "R7 data write ignored", v, 8'h5A);
        peek(2'd1, v); check(v == 8'h30, "R7 addr write ignored", v, 8'h30);
        wait_write(n);
        do_read(8'h30, v); check(v == 8'h5A, "R7 write used original data", v, 8'h5A);
        do_read(8'h31, v); check(v == pat(8'h31), "R7 neighbour untouched", v, pat(8'h31));

        // R2 out of range
        start_write(8'h85, 8'h77);
        wait_write(n);
        check(n == WCYC, "R2 out-of-range write timed", n, WCYC);
        peek(2'd2, v); check(v[4] == 1'b1, "R2 out-of-range WDONE", v[4], 1);
        do_read(8'h05, v); check(v == pat(5), "R2 alias untouched", v, pat(5));
        do_read(8'h85, v); check(v == 8'h00, "R2 out-of-range read zero", v, 0);

        // R9 abort during erase phase
        start_write(8'h0A, 8'h3C);
        @(negedge clk);
        warm_rst = 1'b1; @(negedge clk); warm_rst = 1'b0;
        peek(2'd2, v);
        check(v[3] == 1'b1, "R9 WERR set", v[3], 1);
        check(v[1] == 1'b0 && v[2] == 1'b0, "R9 WRGO WEN cleared", v, 8'h08);
        peek(2'd1, v); check(v == 8'h0A, "R9 addr kept", v, 8'h0A);
        peek(2'd0, v); check(v == 8'h3C, "R9 data kept", v, 8'h3C);
        do_read(8'h0A, v); check(v == pat(10), "R6 byte intact before erase", v, pat(10));
        peek(2'd2, v); check(v[3] == 1'b1, "R9 WERR sticky", v[3], 1);

        // R6 abort during program phase leaves erased byte
        start_write(8'h0B, 8'h3D);
        repeat (ECYC + 1) @(negedge clk);
        warm_rst = 1'b1; @(negedge clk); warm_rst = 1'b0;
        do_read(8'h0B, v); check(v == 8'hFF, "R6 erased before program", v, 8'hFF);

        bus_write(2'd2, 8'h10);
        peek(2'd2, v); check(v[3] == 1'b0, "R9 WERR cleared by 0", v[3], 0);
        @(negedge clk);
        warm_rst = 1'b1; @(negedge clk); warm_rst = 1'b0;
        peek(2'd2, v); check(v[3] == 1'b0, "R9 idle warm reset no WERR", v[3], 0);

        start_write(8'h0B, 8'h3D);
        wait_write(n);
        do_read(8'h0B, v); check(v == 8'h3D, "R9 retry succeeds", v, 8'h3D);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule